// File: doc/BRIEF.md
# Single-Channel Bus-Request Block Mover

This block moves a block of words between one peripheral and memory while the processor stays off the bus. Software loads a start address, a word count and a control word through a small register port while the block is idle. Writing the control word with its go bit set arms the channel. From then on the peripheral drives the transfers by holding its request line.

On a request, the block raises a bus request and waits for the processor to hand over the bus with a grant. Only in a cycle that follows a sampled grant does it drive the memory address, a single read or write strobe and an acknowledge to the peripheral. The data word itself travels on the shared data bus between the peripheral and memory, and never passes through this block. After each word the address steps up by one and the count steps down by one. While the request and the grant both stay high, the next word follows in the very next clock. Otherwise the bus is handed back, and the saved address and count are used when work resumes.

When the count runs out, the block stops, drops its bus request and raises an interrupt. The interrupt stays high until software writes the control word again.

Top module: `dma_blk_mover`

## Requirements
- R1: Register select codes are 0 = address, 1 = count (zero-extended on read) and 2 = control/status. A control write uses bit 0 for direction (1 = peripheral to memory, which drives the write strobe; 0 = memory to peripheral, which drives the read strobe) and bit 1 as go. A status read returns direction in bit 0, interrupt in bit 1 and busy in bit 2. Select 3 reads as zero.
- R2: After arming, the bus request rises only in response to a peripheral request and stays low while no request is present.
- R3: The memory address enable, the read strobe and the write strobe are active only in a cycle whose preceding clock edge sampled the bus grant high.
- R4: Each transferred word produces exactly one clock of peripheral acknowledge, together with exactly one strobe: the write strobe when direction is 1, the read strobe when direction is 0.
- R5: The address driven for the k-th word of a block is the start address plus k, wrapping modulo 2^ADDR_W. After each word the address register goes up by one and the count register goes down by one.
- R6: While the request and the grant both stay high, words follow one per clock with no idle cycle between them.
- R7: If the peripheral request is low when a word finishes, the bus request drops in the next cycle and the block waits. It resumes from the saved address and count when the request returns.
- R8: If the grant is low when a word finishes, that word still completes. The bus request then drops for one cycle and is raised again. No strobe appears until a new grant is sampled, and the block resumes from the saved address and count.
- R9: When the count reaches zero, the block goes idle, drops its bus request and raises the interrupt. The interrupt stays high until a control write.
- R10: Register writes have no effect while the block is busy, which means from arming until the last word.
- R11: A control write with go set while the count is zero does not arm the block.
- R12: The address and count registers can be read at any time, busy or idle, and show the current progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select for reads and writes |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for the selected register |
| dev_req | input | 1 | Transfer request from the peripheral |
| dev_ack | output | 1 | Acknowledge to the peripheral, one clock per word |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| mem_addr | output | ADDR_W | Memory address, zero when not driving |
| mem_addr_en | output | 1 | Address and strobes driven by this block |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| irq | output | 1 | Block-complete interrupt |

## Verification
The bench builds the block with ADDR_W = 16 and CNT_W = 6. The narrow count makes the largest block of 63 words short enough to run in full, and the 16-bit address lets a block that starts at 0xFFFE wrap through zero. The vector table runs whole blocks in both directions. Directed tests then break a block by dropping the request and by withdrawing the grant, and check the saved progress at the register port before each resume.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_REQ   = 2'd2,
    ST_XFER  = 2'd3
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_NONE  = 2'd3;

  localparam int CTRL_DIR_BIT = 0;
  localparam int CTRL_GO_BIT  = 1;

  localparam int STAT_DIR_BIT  = 0;
  localparam int STAT_IRQ_BIT  = 1;
  localparam int STAT_BUSY_BIT = 2;
  localparam int STAT_W        = 3;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic              ld_dir,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              dir_q,
  output logic              last_word,
  output logic              cnt_zero
);
  import dma_blk_pkg::*;

  // next address: one word up, wrapping at the top of the space
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // next count: one word fewer
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (step) begin
      addr_q <= addr_next(addr_q);
    end else if (ld_addr) begin
      addr_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_next(cnt_q);
    end else if (ld_cnt) begin
      cnt_q <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
    end else if (ld_dir) begin
      dir_q <= wdata[CTRL_DIR_BIT];
    end
  end

  assign last_word = (cnt_q == CNT_W'(1));
  assign cnt_zero  = (cnt_q == '0);
endmodule

// File: rtl/dma_seq.sv
module dma_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic irq_clr,
  input  logic dev_req,
  input  logic bus_grant,
  input  logic last_word,
  output logic bus_req,
  output logic xfer,
  output logic word_done,
  output logic busy,
  output logic irq
);
  import dma_blk_pkg::*;

  dma_state_e state_q, state_d;
  logic       block_end;

  always_comb begin
    state_d   = state_q;
    block_end = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (go) state_d = ST_ARMED;
      ST_ARMED: if (dev_req) state_d = ST_REQ;
      ST_REQ: begin
        if (!dev_req)       state_d = ST_ARMED;
        else if (bus_grant) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (last_word) begin
          state_d   = ST_IDLE;
          block_end = 1'b1;
        end else if (dev_req && bus_grant) begin
          state_d = ST_XFER;
        end else begin
          state_d = ST_ARMED;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq <= 1'b0;
    else if (block_end) irq <= 1'b1;
    else if (irq_clr)   irq <= 1'b0;
  end

  assign xfer      = (state_q == ST_XFER);
  assign bus_req   = (state_q == ST_REQ) || (state_q == ST_XFER);
  assign word_done = xfer;
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/dma_rdmux.sv
module dma_rdmux #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              dir_q,
  input  logic              irq,
  input  logic              busy,
  output logic [ADDR_W-1:0] rdata
);
  import dma_blk_pkg::*;

  logic [STAT_W-1:0] stat;

  always_comb begin
    stat                = '0;
    stat[STAT_DIR_BIT]  = dir_q;
    stat[STAT_IRQ_BIT]  = irq;
    stat[STAT_BUSY_BIT] = busy;
  end

  always_comb begin
    unique case (sel)
      SEL_ADDR:  rdata = addr_q;
      SEL_COUNT: rdata = ADDR_W'(cnt_q);
      SEL_CTRL:  rdata = ADDR_W'(stat);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_blk_mover.sv
module dma_blk_mover #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_en,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              irq
);
  import dma_blk_pkg::*;

  localparam bit WIDTHS_OK = (CNT_W <= ADDR_W) && (ADDR_W >= STAT_W);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              dir_q, last_word, cnt_zero;
  logic              xfer, word_done, busy;
  logic              wr_ok, ld_addr, ld_cnt, ctrl_wr, go, irq_clr;

  // writes are accepted only while idle
  assign wr_ok   = reg_we && !busy && WIDTHS_OK;
  assign ld_addr = wr_ok && (reg_sel == SEL_ADDR);
  assign ld_cnt  = wr_ok && (reg_sel == SEL_COUNT);
  assign ctrl_wr = wr_ok && (reg_sel == SEL_CTRL);
  assign irq_clr = ctrl_wr;
  assign go      = ctrl_wr && reg_wdata[CTRL_GO_BIT] && !cnt_zero;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_addr   (ld_addr),
    .ld_cnt    (ld_cnt),
    .ld_dir    (ctrl_wr),
    .wdata     (reg_wdata),
    .step      (word_done),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q),
    .dir_q     (dir_q),
    .last_word (last_word),
    .cnt_zero  (cnt_zero)
  );

  dma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .irq_clr   (irq_clr),
    .dev_req   (dev_req),
    .bus_grant (bus_grant),
    .last_word (last_word),
    .bus_req   (bus_req),
    .xfer      (xfer),
    .word_done (word_done),
    .busy      (busy),
    .irq       (irq)
  );

  dma_rdmux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rdmux (
    .sel    (reg_sel),
    .addr_q (addr_q),
    .cnt_q  (cnt_q),
    .dir_q  (dir_q),
    .irq    (irq),
    .busy   (busy),
    .rdata  (reg_rdata)
  );

  assign mem_addr_en = xfer;
  assign mem_addr    = xfer ? addr_q : '0;
  assign mem_rd      = xfer && !dir_q;
  assign mem_wr      = xfer && dir_q;
  assign dev_ack     = xfer;
endmodule

// File: rtl/dma_blk_mover_chk.sv
module dma_blk_mover_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_req,
  input logic              bus_grant,
  input logic              bus_req,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_addr_en,
  input logic              dev_ack,
  input logic              irq,
  input logic              reg_we,
  input logic              busy,
  input logic              word_done,
  input logic              irq_clr,
  input logic [ADDR_W-1:0] addr_q,
  input logic [CNT_W-1:0]  cnt_q
);
  // R3: bus lines driven only after a sampled grant
  a_r3_drive_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || mem_addr_en) |-> $past(bus_grant));

  // R4: one strobe with each acknowledge
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> ($countones({mem_rd, mem_wr}) == 1));

  // R2: bus request rises only on a peripheral request
  a_r2_req_from_dev: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(dev_req));

  // R5: address and count step once per word
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R9: interrupt only at count zero with the bus released, held until cleared
  a_r9_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cnt_q == '0) && !bus_req);
  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R10: writes while busy leave the address untouched
  a_r10_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && !word_done) |=> $stable(addr_q));
endmodule

bind dma_blk_mover dma_blk_mover_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dev_req     (dev_req),
  .bus_grant   (bus_grant),
  .bus_req     (bus_req),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_addr_en (mem_addr_en),
  .dev_ack     (dev_ack),
  .irq         (irq),
  .reg_we      (reg_we),
  .busy        (busy),
  .word_done   (word_done),
  .irq_clr     (irq_clr),
  .addr_q      (addr_q),
  .cnt_q       (cnt_q)
);

// File: tb/sim_dma_blk_mover.sv
`timescale 1ns/1ps
module sim_dma_blk_mover;
  localparam int AW = 16;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          dev_req = 1'b0;
  logic          dev_ack;
  logic          bus_req;
  logic          bus_grant = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_addr_en, mem_rd, mem_wr, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dma_blk_mover #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_addr_en(mem_addr_en), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .irq(irq)
  );

  // vectors: start address, word count, direction
  localparam int NV = 6;
  localparam logic [AW-1:0] V_ADDR [NV] = '{16'h0100, 16'h0200, 16'hFFFE, 16'h1234, 16'h0000, 16'h8000};
  localparam int            V_CNT  [NV] = '{1, 5, 3, 63, 2, 7};
  localparam bit            V_DIR  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    tick;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [AW-1:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  // collect acknowledged words until the interrupt or a stop count
  task automatic collect(input logic [AW-1:0] a0, input bit dir, input int stop_at,
                         input string tag, output int got, output int first_c, output int last_c);
    got = 0; first_c = -1; last_c = -1;
    for (int c = 0; c < 200 && irq !== 1'b1 && got < stop_at; c++) begin
      tick;
      if (dev_ack === 1'b1) begin
        chk({tag, " R5 address"}, 32'(mem_addr), 32'(AW'(a0 + AW'(got))));
        chk({tag, " R4 strobe"}, {30'd0, mem_wr, mem_rd}, dir ? 32'd2 : 32'd1);
        if (first_c < 0) first_c = c;
        last_c = c;
        got++;
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] v;
    int got, fc, lc, got2;

    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // reset state (R1, R9)
    chk("R9 reset irq", 32'(irq), 0);
    chk("R2 reset bus_req", 32'(bus_req), 0);
    chk("R4 reset ack", 32'(dev_ack), 0);
    rd(2'd0, v); chk("R1 reset addr", 32'(v), 0);
    rd(2'd2, v); chk("R1 reset status", 32'(v), 0);
    rd(2'd3, v); chk("R1 select 3 zero", 32'(v), 0);

    // vector table: whole blocks with request and grant held
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, V_ADDR[i]);
      wr(2'd1, AW'(V_CNT[i]));
      rd(2'd1, v); chk("R1 count readback", 32'(v), 32'(V_CNT[i]));
      dev_req = 1'b1; bus_grant = 1'b1;
      wr(2'd2, AW'(2 + int'(V_DIR[i])));
      rd(2'd2, v); chk("R1 status busy/dir", 32'(v), 32'(4 + int'(V_DIR[i])));
      collect(V_ADDR[i], V_DIR[i], 1000, "table", got, fc, lc);
      chk("R9 word total", 32'(got), 32'(V_CNT[i]));
      chk("R6 back-to-back", 32'(lc - fc), 32'(V_CNT[i] - 1));
      chk("R9 irq at end", 32'(irq), 1);
      chk("R9 bus_req dropped", 32'(bus_req), 0);
      rd(2'd0, v); chk("R5 final addr", 32'(v), 32'(AW'(V_ADDR[i] + AW'(V_CNT[i]))));
      rd(2'd1, v); chk("R5 final count", 32'(v), 0);
      dev_req = 1'b0;
      wr(2'd2, 16'h0000);
      chk("R9 irq cleared by control write", 32'(irq), 0);
    end

    // R11: go with count zero does not arm
    wr(2'd1, 16'd0);
    dev_req = 1'b1;
    wr(2'd2, 16'h0002);
    repeat (3) tick;
    chk("R11 no bus_req", 32'(bus_req), 0);
    rd(2'd2, v); chk("R11 not busy", 32'(v[2]), 0);
    dev_req = 1'b0;

    // R2 / R10: armed without request
    wr(2'd0, 16'h0400);
    wr(2'd1, 16'd4);
    bus_grant = 1'b1;
    wr(2'd2, 16'h0002);
    repeat (3) tick;
    chk("R2 no request no bus_req", 32'(bus_req), 0);
    wr(2'd0, 16'h5555);
    rd(2'd0, v); chk("R10 addr write ignored", 32'(v), 32'h0400);
    wr(2'd1, 16'd9);
    rd(2'd1, v); chk("R10 count write ignored", 32'(v), 4);
    wr(2'd2, 16'h0000);
    rd(2'd2, v); chk("R10 control write ignored", 32'(v), 4);

    // R7: request withdrawn after two words
    dev_req = 1'b1;
    collect(16'h0400, 1'b0, 2, "R7 first part", got, fc, lc);
    chk("R7 words before drop", 32'(got), 2);
    dev_req = 1'b0;
    tick;
    chk("R7 bus_req released", 32'(bus_req), 0);
    chk("R7 no ack", 32'(dev_ack), 0);
    repeat (3) tick;
    chk("R7 stays released", 32'(bus_req), 0);
    rd(2'd0, v); chk("R12 addr progress", 32'(v), 32'h0402);
    rd(2'd1, v); chk("R12 count progress", 32'(v), 2);
    dev_req = 1'b1;
    collect(16'h0402, 1'b0, 1000, "R7 resume", got2, fc, lc);
    chk("R7 remaining words", 32'(got2), 2);

    // R9: interrupt held until control write
    dev_req = 1'b0;
    repeat (4) tick;
    chk("R9 irq held", 32'(irq), 1);
    wr(2'd0, 16'h0700);
    chk("R9 irq held over addr write", 32'(irq), 1);
    wr(2'd1, 16'd6);
    wr(2'd2, 16'h0001);
    chk("R9 irq cleared", 32'(irq), 0);

    // R8: grant withdrawn mid-block
    dev_req = 1'b1; bus_grant = 1'b1;
    wr(2'd2, 16'h0003);
    collect(16'h0700, 1'b1, 2, "R8 first part", got, fc, lc);
    chk("R8 words before loss", 32'(got), 2);
    bus_grant = 1'b0;
    tick;
    chk("R8 bus released", 32'(bus_req), 0);
    chk("R8 no strobe", 32'({mem_wr, mem_rd, mem_addr_en}), 0);
    tick;
    chk("R8 request raised again", 32'(bus_req), 1);
    repeat (3) tick;
    chk("R8 waits for grant", 32'({dev_ack, mem_wr}), 0);
    rd(2'd0, v); chk("R8 saved addr", 32'(v), 32'h0702);
    rd(2'd1, v); chk("R8 saved count", 32'(v), 4);
    bus_grant = 1'b1;
    collect(16'h0702, 1'b1, 1000, "R8 resume", got2, fc, lc);
    chk("R8 remaining words", 32'(got2), 4);
    chk("R8 irq at end", 32'(irq), 1);
    dev_req = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule